// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events for one processor core. It holds one cycle counter and `NUM_CNT` event counters, each 32 bits wide. Each event counter is set up through a type word. The type word picks one of the core's event lines by number and says at which privilege levels the counter may count. The core reports each event as a one-cycle pulse on `evt_in` and reports its current privilege level on `priv_lvl`.

Software reaches the unit through a single-cycle register bus. Reads are combinational and writes take effect at the clock edge. Counters and interrupt sources are switched on and off through paired set and clear registers. When a counter wraps, its overflow flag is raised, and the flags drive one shared interrupt line. A select register directs the indirect count and type registers to one event counter. The cycle counter has its own count register. It can run at the full clock rate or at one sixty-fourth of it, and it can be held while debug is prohibited.

Top module: `pmu_core`

## Requirements
- R1: After reset, all counts, enables, interrupt enables, overflow flags, the select value and the stored control bits are 0, and `irq` is low.
- R2: The control register (address 0) stores bit 0 (global run), bit 3 (divide mode), bit 4 (export, no effect) and bit 5 (debug hold). Bits 2:1 and 10:6 read as 0. Bits 15:11 read as `NUM_CNT`.
- R3: Writing 1 to control bit 1 clears every event counter in that cycle. Writing 1 to control bit 2 clears the cycle counter and its prescaler. Either clear takes priority over counting.
- R4: When control bit 3 is 1, the cycle counter advances once per 64 counting cycles. When it is 0, the cycle counter advances on every counting cycle.
- R5: When control bit 5 is 1 and `dbg_prohibit` is high, the cycle counter holds.
- R6: Counter enables are set at address 1 and cleared at address 2. Interrupt enables are set at address 3 and cleared at address 4. Event counter n uses bit n and the cycle counter uses bit 31. A 1 bit acts, a 0 bit has no effect, and bits for counters that do not exist stay 0. Either address of a pair reads the current mask.
- R7: A counter advances only while control bit 0 and its own enable bit are both 1.
- R8: The type register (address 9) keeps only bits 31, 30, 27 and 7:0, so the write mask is 0xC80000FF. The `priv_lvl` encoding is 0 user, 1 privileged, 2 hypervisor and 3 none. A counter counts at user level unless bit 30 is set, counts at privileged level unless bit 31 is set, counts at hypervisor level only if bit 27 is set, and never counts at level 3.
- R9: Event number 0x11 counts every clock cycle. Any other event number k below `EVT_LINES` counts pulses on `evt_in[k]`. Event numbers at or above `EVT_LINES` count nothing. Line 0x11 of `evt_in` is never used.
- R10: A counter that steps from 0xFFFFFFFF to 0 sets its overflow flag (address 5). Writing 1 to a flag clears it, and a wrap in the same cycle wins over the clear.
- R11: `irq` is high exactly when some overflow flag is set and its interrupt enable is also set.
- R12: The select register (address 6) holds 5 bits. The count register at address 8 and the type register act on the selected event counter. When the selected counter does not exist, both read 0 and writes to them are ignored.
- R13: Writing address 8 loads the selected event counter, and writing address 7 loads the cycle counter. A load takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| evt_in | input | EVT_LINES | One-cycle event pulses, indexed by event number |
| priv_lvl | input | 2 | Current privilege level of the core |
| dbg_prohibit | input | 1 | High while debug is prohibited |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The hold properties assume that a bus write lasts a single cycle and that a counter is loaded or cleared only through its own address, so any change to a stalled counter must come from a visible register access. The overflow-flag property assumes a flag is raised only in the cycle right after the counter wraps. The stimulus drives the bus, `evt_in`, `priv_lvl` and `dbg_prohibit` only on falling edges. Writes are one cycle long. When the bench stops the counters, it first parks `priv_lvl` at level 3, so the edge that turns the run bit off adds nothing and the expected counts from the bench model stay exact.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int CYC_BIT = 31;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_EN_SET = 4'd1;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 4'd2;
    localparam logic [ADDR_W-1:0] A_IE_SET = 4'd3;
    localparam logic [ADDR_W-1:0] A_IE_CLR = 4'd4;
    localparam logic [ADDR_W-1:0] A_OVF    = 4'd5;
    localparam logic [ADDR_W-1:0] A_SEL    = 4'd6;
    localparam logic [ADDR_W-1:0] A_CYC    = 4'd7;
    localparam logic [ADDR_W-1:0] A_EVCNT  = 4'd8;
    localparam logic [ADDR_W-1:0] A_EVTYPE = 4'd9;

    localparam logic [7:0] EV_CYCLES = 8'h11;

    typedef enum logic [1:0] {
        PRIV_USER = 2'd0,
        PRIV_KERN = 2'd1,
        PRIV_HYP  = 2'd2,
        PRIV_NONE = 2'd3
    } priv_e;

    typedef struct packed {
        logic       no_kern;
        logic       no_user;
        logic       with_hyp;
        logic [7:0] num;
    } evt_cfg_t;

    typedef struct packed {
        logic dbg_stop;
        logic export_en;
        logic div64;
        logic run_all;
    } ctrl_t;
endpackage

// File: rtl/pmu_ctrl_regs.sv
`timescale 1ns/1ps
module pmu_ctrl_regs
    import pmu_pkg::*;
#(
    parameter int NUM_CNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] en_mask,
    output logic [DATA_W-1:0] ie_mask,
    output logic [4:0]        sel,
    output logic              clr_evt,
    output logic              clr_cyc
);
    localparam logic [DATA_W-1:0] EVT_BITS  = (32'd1 << NUM_CNT) - 32'd1;
    localparam logic [DATA_W-1:0] IMPL_MASK = EVT_BITS | (32'd1 << CYC_BIT);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] ie;
        logic [4:0]        sel;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        clr_evt = 1'b0;
        clr_cyc = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    st_d.ctrl.dbg_stop  = bus_wdata[5];
                    st_d.ctrl.export_en = bus_wdata[4];
                    st_d.ctrl.div64     = bus_wdata[3];
                    st_d.ctrl.run_all   = bus_wdata[0];
                    clr_cyc             = bus_wdata[2];
                    clr_evt             = bus_wdata[1];
                end
                A_EN_SET: st_d.en  = st_q.en | (bus_wdata & IMPL_MASK);
                A_EN_CLR: st_d.en  = st_q.en & ~bus_wdata;
                A_IE_SET: st_d.ie  = st_q.ie | (bus_wdata & IMPL_MASK);
                A_IE_CLR: st_d.ie  = st_q.ie & ~bus_wdata;
                A_SEL:    st_d.sel = bus_wdata[4:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl    = st_q.ctrl;
    assign en_mask = st_q.en;
    assign ie_mask = st_q.ie;
    assign sel     = st_q.sel;

    // R6: a clear write leaves none of its bits set
    assert_en_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_EN_CLR) |=> ((st_q.en & $past(bus_wdata)) == '0));

    // R6: bits of absent counters never become set
    assert_impl_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_IE_SET) |=> ((st_q.ie & ~IMPL_MASK) == '0));
endmodule

// File: rtl/pmu_evt_counter.sv
`timescale 1ns/1ps
module pmu_evt_counter
    import pmu_pkg::*;
#(
    parameter int EVT_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 count_en,
    input  logic [EVT_LINES-1:0] evt_in,
    input  logic [1:0]           priv_lvl,
    input  logic                 wr_cnt,
    input  logic                 wr_type,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 clr_cnt,
    output logic [DATA_W-1:0]    count,
    output evt_cfg_t             cfg,
    output logic                 wrap
);
    localparam int LW = (EVT_LINES > 1) ? $clog2(EVT_LINES) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] count;
        evt_cfg_t          cfg;
    } cnt_t;

    cnt_t  st_d, st_q;
    logic  hit, lvl_ok, inc;
    priv_e lvl;

    always_comb begin
        lvl = priv_e'(priv_lvl);
        case (lvl)
            PRIV_USER: lvl_ok = !st_q.cfg.no_user;
            PRIV_KERN: lvl_ok = !st_q.cfg.no_kern;
            PRIV_HYP:  lvl_ok = st_q.cfg.with_hyp;
            default:   lvl_ok = 1'b0;
        endcase

        if (st_q.cfg.num == EV_CYCLES)
            hit = 1'b1;
        else if (int'({24'd0, st_q.cfg.num}) < EVT_LINES)
            hit = evt_in[st_q.cfg.num[LW-1:0]];
        else
            hit = 1'b0;

        inc  = count_en && hit && lvl_ok;
        st_d = st_q;
        wrap = 1'b0;
        if (clr_cnt) begin
            st_d.count = '0;
        end else if (wr_cnt) begin
            st_d.count = wdata;
        end else if (inc) begin
            st_d.count = st_q.count + 1'b1;
            wrap       = &st_q.count;
        end
        if (wr_type) begin
            st_d.cfg.no_kern  = wdata[31];
            st_d.cfg.no_user  = wdata[30];
            st_d.cfg.with_hyp = wdata[27];
            st_d.cfg.num      = wdata[7:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign cfg   = st_q.cfg;

    // R7: a counter that is not enabled and not accessed holds its value
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !wr_cnt && !clr_cnt) |=> $stable(st_q.count));

    // R3: a clear leaves the counter at zero
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (st_q.count == '0));
endmodule

// File: rtl/pmu_cyc_counter.sv
`timescale 1ns/1ps
module pmu_cyc_counter
    import pmu_pkg::*;
#(
    parameter int DIV_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              div_en,
    input  logic              wr_cnt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_cnt,
    output logic [DATA_W-1:0] count,
    output logic              wrap
);
    typedef struct packed {
        logic [DATA_W-1:0]   count;
        logic [DIV_LOG2-1:0] pre;
    } cyc_t;

    cyc_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        tick = run && (!div_en || (&st_q.pre));
        if (run && div_en)
            st_d.pre = st_q.pre + 1'b1;
        if (clr_cnt) begin
            st_d.count = '0;
            st_d.pre   = '0;
        end else if (wr_cnt) begin
            st_d.count = wdata;
        end else if (tick) begin
            st_d.count = st_q.count + 1'b1;
            wrap       = &st_q.count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

    // R4: in divide mode, the count holds until the prescaler is full
    assert_div_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && !(&st_q.pre) && !wr_cnt && !clr_cnt) |=> $stable(st_q.count));
endmodule

// File: rtl/pmu_core.sv
`timescale 1ns/1ps
module pmu_core
    import pmu_pkg::*;
#(
    parameter int NUM_CNT   = 4,
    parameter int EVT_LINES = 32,
    parameter int DIV_LOG2  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [EVT_LINES-1:0] evt_in,
    input  logic [1:0]           priv_lvl,
    input  logic                 dbg_prohibit,
    output logic                 irq
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] en_mask, ie_mask;
    logic [4:0]        sel;
    logic              clr_evt, clr_cyc;

    logic [DATA_W-1:0] evt_count [NUM_CNT];
    evt_cfg_t          evt_cfg   [NUM_CNT];
    logic [NUM_CNT-1:0] evt_wrap;
    logic [DATA_W-1:0] cyc_count;
    logic              cyc_wrap, cyc_run, sel_ok;
    logic [DATA_W-1:0] sel_count, sel_type, wrap_vec, w1c;

    typedef struct packed {
        logic [DATA_W-1:0] flags;
    } top_t;
    top_t st_d, st_q;

    pmu_ctrl_regs #(.NUM_CNT(NUM_CNT)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl      (ctrl),
        .en_mask   (en_mask),
        .ie_mask   (ie_mask),
        .sel       (sel),
        .clr_evt   (clr_evt),
        .clr_cyc   (clr_cyc)
    );

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pmu_evt_counter #(.EVT_LINES(EVT_LINES)) cnt_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_en (ctrl.run_all && en_mask[g]),
            .evt_in   (evt_in),
            .priv_lvl (priv_lvl),
            .wr_cnt   (bus_we && bus_addr == A_EVCNT && sel == 5'(g)),
            .wr_type  (bus_we && bus_addr == A_EVTYPE && sel == 5'(g)),
            .wdata    (bus_wdata),
            .clr_cnt  (clr_evt),
            .count    (evt_count[g]),
            .cfg      (evt_cfg[g]),
            .wrap     (evt_wrap[g])
        );
    end

    assign cyc_run = ctrl.run_all && en_mask[CYC_BIT] && !(ctrl.dbg_stop && dbg_prohibit);

    pmu_cyc_counter #(.DIV_LOG2(DIV_LOG2)) cyc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cyc_run),
        .div_en  (ctrl.div64),
        .wr_cnt  (bus_we && bus_addr == A_CYC),
        .wdata   (bus_wdata),
        .clr_cnt (clr_cyc),
        .count   (cyc_count),
        .wrap    (cyc_wrap)
    );

    always_comb begin
        sel_ok    = int'({27'd0, sel}) < NUM_CNT;
        sel_count = '0;
        sel_type  = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (sel == 5'(i)) begin
                sel_count = evt_count[i];
                sel_type  = {evt_cfg[i].no_kern, evt_cfg[i].no_user, 2'b00,
                             evt_cfg[i].with_hyp, 19'd0, evt_cfg[i].num};
            end
        end

        wrap_vec                = '0;
        wrap_vec[NUM_CNT-1:0]   = evt_wrap;
        wrap_vec[CYC_BIT]       = cyc_wrap;
        w1c                     = (bus_we && bus_addr == A_OVF) ? bus_wdata : '0;
        st_d.flags              = (st_q.flags & ~w1c) | wrap_vec;

        case (bus_addr)
            A_CTRL:   bus_rdata = {16'd0, 5'(NUM_CNT), 5'd0, ctrl.dbg_stop,
                                   ctrl.export_en, ctrl.div64, 2'b00, ctrl.run_all};
            A_EN_SET,
            A_EN_CLR: bus_rdata = en_mask;
            A_IE_SET,
            A_IE_CLR: bus_rdata = ie_mask;
            A_OVF:    bus_rdata = st_q.flags;
            A_SEL:    bus_rdata = {27'd0, sel};
            A_CYC:    bus_rdata = cyc_count;
            A_EVCNT:  bus_rdata = sel_count;
            A_EVTYPE: bus_rdata = sel_type;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = |(st_q.flags & ie_mask);

    // R10: a wrap always leaves its flag set, even against a clear
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|wrap_vec) |=> ((st_q.flags & $past(wrap_vec)) == $past(wrap_vec)));

    // R5: debug hold freezes the cycle counter
    assert_dbg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.dbg_stop && dbg_prohibit &&
         !(bus_we && (bus_addr == A_CYC || bus_addr == A_CTRL))) |=> $stable(cyc_count));

    // R12: an absent selected counter reads as zero
    assert_sel_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_EVCNT && !sel_ok) |-> (bus_rdata == '0));

    // R11: no interrupt without an enabled flag after a full flag clear
    assert_irq_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_OVF && (&bus_wdata) && !(|wrap_vec)) |=> !irq);
endmodule

// File: tb/pmu_core_tb_top.sv
`timescale 1ns/1ps
module pmu_core_tb_top;
    localparam int NC = 4;
    localparam int EL = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [EL-1:0] evt_in = '0;
    logic [1:0]  priv_lvl = 2'd3;
    logic        dbg_prohibit = 1'b0;
    logic        irq;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    pmu_core #(.NUM_CNT(NC), .EVT_LINES(EL), .DIV_LOG2(6)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .evt_in       (evt_in),
        .priv_lvl     (priv_lvl),
        .dbg_prohibit (dbg_prohibit),
        .irq          (irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic drive(input int n, input logic [31:0] ev, input logic [1:0] pr);
        for (int k = 0; k < n; k++) begin
            evt_in = ev; priv_lvl = pr;
            @(negedge clk);
        end
        evt_in = '0; priv_lvl = 2'd3;
    endtask

    task automatic read_evt(input int idx, output logic [31:0] d);
        bus_wr(4'd6, 32'(idx));
        bus_rd(4'd8, d);
    endtask

    function automatic logic exp_hit(input logic [31:0] t, input logic [31:0] ev,
                                     input logic [1:0] pr);
        logic ok;
        logic src;
        case (pr)
            2'd0:    ok = !t[30];
            2'd1:    ok = !t[31];
            2'd2:    ok = t[27];
            default: ok = 1'b0;
        endcase
        if (t[7:0] == 8'h11)   src = 1'b1;
        else if (t[7:0] < 8'd32) src = ev[t[4:0]];
        else                     src = 1'b0;
        return ok && src;
    endfunction

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog R1 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] r2;
        logic [7:0]  picks [8];
        logic [31:0] tval [NC];
        int unsigned ecount [NC];
        void'($urandom(32'd4242));
        picks = '{8'h08, 8'h10, 8'h11, 8'h03, 8'h1F, 8'h40, 8'hFF, 8'h00};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_rd(4'd0, r); chk("R1", "ctrl after reset", r, 32'h0000_2000);
        bus_rd(4'd1, r); chk("R1", "enables after reset", r, 32'h0);
        @(negedge clk);
        bus_rd(4'd5, r); chk("R1", "flags after reset", r, 32'h0);
        bus_rd(4'd7, r); chk("R1", "cycle count after reset", r, 32'h0);
        chk("R1", "irq after reset", {31'd0, irq}, 32'h0);

        // R2 control register layout
        bus_wr(4'd0, 32'hFFFF_FFFF);
        bus_rd(4'd0, r); chk("R2", "ctrl writable bits", r, 32'h0000_2039);
        bus_wr(4'd0, 32'h0);

        // R6 set/clear enables
        bus_wr(4'd1, 32'h8000_0005);
        bus_rd(4'd1, r); chk("R6", "enable set", r, 32'h8000_0005);
        bus_wr(4'd1, 32'h0);
        bus_rd(4'd2, r); chk("R6", "zero set write no effect", r, 32'h8000_0005);
        bus_wr(4'd2, 32'h0000_0001);
        bus_rd(4'd1, r); chk("R6", "enable clear", r, 32'h8000_0004);
        bus_wr(4'd1, 32'hFFFF_FFFF);
        bus_rd(4'd2, r); chk("R6", "absent counters stay 0", r, 32'h8000_000F);
        bus_wr(4'd2, 32'hFFFF_FFFF);

        // R8 type write mask
        bus_wr(4'd6, 32'd0);
        bus_wr(4'd9, 32'hFFFF_FFFF);
        bus_rd(4'd9, r); chk("R8", "type write mask", r, 32'hC800_00FF);

        // R13 direct loads
        bus_wr(4'd7, 32'h0000_1234);
        bus_rd(4'd7, r); chk("R13", "cycle count load", r, 32'h0000_1234);

        // R10 / R11 overflow of counter 1 counting cycles
        bus_wr(4'd6, 32'd1);
        bus_wr(4'd9, 32'h0000_0011);
        bus_wr(4'd8, 32'hFFFF_FFFE);
        bus_rd(4'd8, r); chk("R13", "event count load", r, 32'hFFFF_FFFE);
        bus_wr(4'd1, 32'h0000_0002);
        bus_wr(4'd3, 32'h0000_0002);
        priv_lvl = 2'd0;
        bus_wr(4'd0, 32'h1);
        @(negedge clk);
        @(negedge clk);
        chk("R11", "irq after wrap", {31'd0, irq}, 32'h1);
        bus_rd(4'd8, r);  chk("R10", "count after wrap", r, 32'h0);
        bus_rd(4'd5, r2); chk("R10", "flag after wrap", r2, 32'h0000_0002);
        bus_wr(4'd5, 32'h0);
        bus_rd(4'd5, r); chk("R10", "zero w1c no effect", r, 32'h0000_0002);
        bus_wr(4'd5, 32'h0000_0002);
        bus_rd(4'd5, r); chk("R10", "flag cleared", r, 32'h0);
        chk("R11", "irq after clear", {31'd0, irq}, 32'h0);
        priv_lvl = 2'd3;
        bus_wr(4'd0, 32'h0);
        bus_wr(4'd2, 32'hFFFF_FFFF);
        bus_wr(4'd4, 32'hFFFF_FFFF);

        // R4 divide by 64
        bus_wr(4'd1, 32'h8000_0000);
        bus_wr(4'd0, 32'h0000_000D);
        repeat (130) @(negedge clk);
        bus_rd(4'd7, r); chk("R4", "divided cycle count", r, 32'd2);
        bus_wr(4'd0, 32'h0000_0005);
        repeat (10) @(negedge clk);
        bus_rd(4'd7, r); chk("R4", "undivided cycle count", r, 32'd10);

        // R5 debug hold
        dbg_prohibit = 1'b1;
        bus_wr(4'd0, 32'h0000_0025);
        repeat (10) @(negedge clk);
        bus_rd(4'd7, r); chk("R5", "held while prohibited", r, 32'd0);
        dbg_prohibit = 1'b0;
        repeat (5) @(negedge clk);
        bus_rd(4'd7, r); chk("R5", "runs after release", r, 32'd5);
        dbg_prohibit = 1'b1;
        bus_wr(4'd0, 32'h0000_0005);
        repeat (7) @(negedge clk);
        bus_rd(4'd7, r); chk("R5", "hold bit off ignores prohibit", r, 32'd7);
        dbg_prohibit = 1'b0;
        bus_wr(4'd0, 32'h0);
        bus_wr(4'd2, 32'hFFFF_FFFF);

        // R3 clear all event counters
        bus_wr(4'd6, 32'd0);
        bus_wr(4'd8, 32'd123);
        bus_wr(4'd0, 32'h0000_0002);
        bus_rd(4'd8, r); chk("R3", "event counter cleared", r, 32'd0);

        // R12 out-of-range select
        bus_wr(4'd6, 32'd7);
        bus_wr(4'd8, 32'd55);
        bus_rd(4'd8, r); chk("R12", "absent counter reads 0", r, 32'd0);
        bus_rd(4'd9, r); chk("R12", "absent type reads 0", r, 32'd0);
        read_evt(0, r); chk("R12", "ignored write kept counter 0", r, 32'd0);
        bus_wr(4'd6, 32'hFF);
        bus_rd(4'd6, r); chk("R12", "select width", r, 32'h1F);

        // R7 / R8 directed privilege filter on counter 2
        bus_wr(4'd6, 32'd2);
        bus_wr(4'd9, 32'h4000_0008);
        bus_wr(4'd1, 32'h0000_0004);
        bus_wr(4'd0, 32'h1);
        drive(3, 32'h100, 2'd0);
        drive(4, 32'h100, 2'd1);
        drive(2, 32'h100, 2'd2);
        bus_wr(4'd0, 32'h0);
        read_evt(2, r); chk("R8", "user excluded, hyp not included", r, 32'd4);
        bus_wr(4'd2, 32'h0000_0004);
        bus_wr(4'd0, 32'h1);
        drive(5, 32'h100, 2'd1);
        bus_wr(4'd0, 32'h0);
        read_evt(2, r); chk("R7", "disabled counter holds", r, 32'd4);

        // R7 / R8 / R9 random rounds
        for (int round = 0; round < 6; round++) begin
            bus_wr(4'd0, 32'h0000_0002);
            for (int i = 0; i < NC; i++) begin
                tval[i] = ($urandom & 32'hC800_0000) | {24'd0, picks[$urandom % 8]};
                ecount[i] = 0;
                bus_wr(4'd6, 32'(i));
                bus_wr(4'd9, tval[i] | 32'h0300_FF00);
            end
            bus_wr(4'd1, 32'h0000_000F);
            bus_wr(4'd0, 32'h1);
            for (int c = 0; c < 200; c++) begin
                logic [31:0] ev;
                logic [1:0]  pr;
                ev = $urandom;
                pr = 2'($urandom % 4);
                evt_in = ev; priv_lvl = pr;
                for (int i = 0; i < NC; i++)
                    if (exp_hit(tval[i], ev, pr)) ecount[i]++;
                @(negedge clk);
            end
            evt_in = '0; priv_lvl = 2'd3;
            bus_wr(4'd0, 32'h0);
            for (int i = 0; i < NC; i++) begin
                read_evt(i, r);
                chk("R9", $sformatf("round %0d counter %0d", round, i), r, ecount[i]);
            end
            bus_rd(4'd9, r); chk("R8", "random type readback", r, tval[NC-1]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule